// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block controls the power states of a pseudo-static RAM that has an active-low chip select and an active-low deep-sleep pin. After supply power is reported good, it holds the memory deselected and awake for a long start-up interval. It then tells the access controller that memory cycles may be issued. On request it puts the memory into deep sleep, waits out the settling interval the memory needs before deep sleep takes effect, and on a wake request repeats the full start-up interval.

The memory does not keep its contents in deep sleep. For this reason the block raises a flag when it becomes ready after a wake-up, and that flag tells the access controller that the contents are invalid. All intervals are counted in clock cycles. They are derived from parameters for the clock rate, the start-up hold in milliseconds and the settling time in microseconds, so a testbench can use scaled-down values.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, and afterwards while `pwr_good` stays low, the block drives `cs_hold`=1, `zz_n`=1, `ready`=0 and `data_lost`=0.
- R2: Once `pwr_good` is sampled high out of the reset state, `cs_hold` and `zz_n` stay high and `ready` stays low for exactly HOLD_CYC = CLK_KHZ*HOLD_MS clock cycles. `ready` rises on the edge that ends that interval.
- R3: `ready` is high only in the ready state, and `cs_hold` is its inverse. The memory may be selected only while `ready` is high.
- R4: A `sleep_req` sampled high while ready drives `zz_n` low and `ready` low on the next edge. `zz_n` then stays low for SUSP_CYC = ceil(CLK_KHZ*SUSPEND_US/1000) settling cycles (at least 1), after which deep sleep is in effect.
- R5: A `sleep_req` during the start-up or wake-up hold has no effect during the hold. If it is still high on the first ready cycle, it is acted on there, so `ready` lasts one cycle.
- R6: A `wake_req` sampled high in deep sleep drives `zz_n` high on the next edge and starts a hold of HOLD_CYC cycles with `cs_hold` high, ending in ready. A `wake_req` while ready or while settling has no effect.
- R7: `data_lost` is high for the whole ready period that follows a wake-up. It is low in every other state and low after a plain start-up.
- R8: `pwr_good` sampled low in any state returns the block to the reset state on the next edge, which drops `ready` and `data_lost` and drives `zz_n` high.
- R9: During settling and deep sleep, `zz_n` is low and `cs_hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is stable |
| sleep_req | input | 1 | Level request to enter deep sleep |
| wake_req | input | 1 | Level request to leave deep sleep |
| cs_hold | output | 1 | Chip select must be held high (deselected) |
| zz_n | output | 1 | Level required on the memory's deep-sleep pin |
| ready | output | 1 | Memory cycles may be issued |
| data_lost | output | 1 | Memory contents invalid after a wake-up |

## Verification
The assertions assume that `sleep_req`, `wake_req` and `pwr_good` are synchronous to `clk` and are sampled as levels. They also assume that an asserted request acts on the first edge at which it is legal. The stimulus changes inputs only on falling edges. It holds `sleep_req` through a whole start-up hold, pulses `wake_req` while the block is settling and while it is ready, and drops `pwr_good` in the middle of a wake-up hold and while ready. The reference model is updated from the same inputs at each rising edge.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int CLK_KHZ    = 100000,
  parameter int HOLD_MS    = 200,
  parameter int SUSPEND_US = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sleep_req,
  input  logic wake_req,
  output logic cs_hold,
  output logic zz_n,
  output logic ready,
  output logic data_lost
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int SUSP_RAW = (CLK_KHZ * SUSPEND_US + 999) / 1000;
  localparam int SUSP_CYC = (SUSP_RAW < 1) ? 1 : SUSP_RAW;
  localparam int MAX_CYC  = (HOLD_CYC > SUSP_CYC) ? HOLD_CYC : SUSP_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_RESET, S_INIT, S_READY, S_SETTLE, S_DEEP, S_WAKE
  } pstate_t;

  pstate_t         state, nxt;
  logic [CW-1:0]   cnt;
  logic            hold_done, settle_done, waiting;

  assign hold_done   = (cnt == CW'(HOLD_CYC - 1));
  assign settle_done = (cnt == CW'(SUSP_CYC - 1));
  assign waiting     = (state == S_INIT) || (state == S_WAKE) || (state == S_SETTLE);

  always_comb begin
    nxt = state;
    if (!pwr_good) nxt = S_RESET;
    else begin
      case (state)
        S_RESET:  nxt = S_INIT;
        S_INIT:   if (hold_done) nxt = S_READY;
        S_READY:  if (sleep_req) nxt = S_SETTLE;
        S_SETTLE: if (settle_done) nxt = S_DEEP;
        S_DEEP:   if (wake_req) nxt = S_WAKE;
        S_WAKE:   if (hold_done) nxt = S_READY;
        default:  nxt = S_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RESET;
      cnt       <= '0;
      data_lost <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || !waiting) cnt <= '0;
      else                          cnt <= cnt + 1'b1;
      if (state == S_WAKE && nxt == S_READY) data_lost <= 1'b1;
      else if (nxt != S_READY)               data_lost <= 1'b0;
    end
  end

  assign ready   = (state == S_READY);
  assign cs_hold = !ready;
  assign zz_n    = !((state == S_SETTLE) || (state == S_DEEP));

  // R4
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sleep_req && pwr_good) |=> (!zz_n && !ready));

  // R5
  sleep_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && zz_n && sleep_req) |=> zz_n);

  // R6
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEEP && wake_req && pwr_good) |=> (zz_n && cs_hold));

  // R8
  power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!ready && !data_lost && zz_n));

  // R7
  lost_only_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> $rose(ready));

  // R2
  ready_from_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(zz_n) && $past(cs_hold)));

  // R9
  sleep_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zz_n |-> (cs_hold && !data_lost));
endmodule

// File: tb/tb_psram_pwr_seq.sv
module tb_psram_pwr_seq;
  localparam int CLK_KHZ = 10, HOLD_MS = 2, SUSPEND_US = 500;
  localparam int HOLD = CLK_KHZ * HOLD_MS;
  localparam int SUSP = (CLK_KHZ * SUSPEND_US + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic cs_hold, zz_n, ready, data_lost;

  psram_pwr_seq #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS), .SUSPEND_US(SUSPEND_US)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
    .wake_req(wake_req), .cs_hold(cs_hold), .zz_n(zz_n), .ready(ready),
    .data_lost(data_lost));

  always #5 clk = ~clk;

  // model: 0 off, 1 start-up, 2 ready, 3 settling, 4 deep, 5 waking
  integer mode = 0, left = 0, lost = 0;
  integer vectors = 0, misses = 0, cycles = 0;
  string  tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; lost = 0;
    end else if (!pwr_good) begin
      mode = 0; lost = 0;
    end else begin
      case (mode)
        0: begin mode = 1; left = HOLD; end
        1: begin left = left - 1; if (left == 0) mode = 2; end
        2: if (sleep_req) begin mode = 3; left = SUSP; lost = 0; end
        3: begin left = left - 1; if (left == 0) mode = 4; end
        4: if (wake_req) begin mode = 5; left = HOLD; end
        5: begin left = left - 1; if (left == 0) begin mode = 2; lost = 1; end end
        default: mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic e_rdy, e_zz;
    e_rdy = (mode == 2);
    e_zz  = !(mode == 3 || mode == 4);
    case (mode)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R9";
      default: tag = "R6";
    endcase
    vectors++;
    if (ready !== e_rdy || cs_hold !== !e_rdy || zz_n !== e_zz) begin
      misses++;
      $display("FAIL %s t=%0t ready/cs_hold/zz_n=%b%b%b expected %b%b%b",
               tag, $time, ready, cs_hold, zz_n, e_rdy, !e_rdy, e_zz);
    end
    vectors++;
    if (data_lost !== (lost != 0)) begin
      misses++;
      $display("FAIL R7 t=%0t data_lost=%b expected %b", $time, data_lost, lost != 0);
    end
    cycles++;
    if (cycles > 5000) begin
      misses++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);                                 // R1: no power yet
    pwr_good = 1'b1; sleep_req = 1'b1;       // R5: sleep held through start-up
    idle(HOLD + 3);
    sleep_req = 1'b0;
    idle(2);
    wake_req = 1'b1; idle(2); wake_req = 1'b0; // R6: ignored while settling
    idle(SUSP + 4);
    wake_req = 1'b1; idle(1); wake_req = 1'b0; // R6: wake from deep
    idle(HOLD + 6);                          // R7: ready with contents lost
    wake_req = 1'b1; idle(2); wake_req = 1'b0; // R6: ignored while ready
    sleep_req = 1'b1; idle(1); sleep_req = 1'b0;
    idle(SUSP + 3);
    wake_req = 1'b1; idle(1); wake_req = 1'b0;
    idle(HOLD / 2);
    pwr_good = 1'b0; idle(3);                // R8: loss mid wake-up
    pwr_good = 1'b1; idle(HOLD + 5);         // R7: plain start-up, no loss flag
    pwr_good = 1'b0; idle(2);                // R8: loss while ready
    pwr_good = 1'b1; idle(HOLD + 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule